// File: doc/BRIEF.md
# PLL Divider Parameter Search Engine

This block picks the feedback multiplier M and the input pre-divider N of a clock-generation PLL for a requested per-lane serial data rate and a known reference frequency. Both values arrive as integers in kHz with a one-cycle start pulse. The engine first checks both inputs against their legal ranges. It then sets the target output frequency to half the lane rate and chooses a post-VCO divider from that target. It walks through the legal N values one per iteration and, for each one, computes a rounded M and the output frequency that M would give. One shared multi-cycle divider does all the arithmetic.

The closest legal candidate is kept. When the walk ends, the engine raises a one-cycle done pulse. With it come M, N, the post-divider, the achieved output frequency and an error flag. M and N are also given in offset form (M minus two, N minus one) so that a register packer can take them directly. A system controller or boot sequencer issues a request and waits for done before it programs the PLL.

Top module: `pll_ratio_search`

## Requirements
- R1: A request whose lane rate is below 80000 kHz or above 2500000 kHz ends with done and err_o high. The bounds themselves are legal.
- R2: A request whose reference is below 2000 kHz or above 64000 kHz ends with done and err_o high. The bounds themselves are legal.
- R3: With target Fout = floor(rate/2) kHz, the post-divider is 8 when Fout <= 80000, 4 when Fout <= 160000, 2 when Fout <= 320000, and 1 otherwise.
- R4: N runs from ceil(Fin/8000) to min(floor(Fin/2000), 16), with 1 as the lowest value. For each N, M = floor((Fout*N*div + floor(Fin/2)) / Fin). A candidate whose M lies outside 64..625 is discarded.
- R5: The achieved frequency is floor(M*Fin / (N*div)) kHz. A candidate whose achieved frequency lies outside 40000..1250000 kHz is discarded.
- R6: The reported candidate has the smallest |Fout - achieved|. On a tie, the candidate with the lower N is kept.
- R7: When a request fails (R1, R2, or no surviving candidate), err_o is high with done. M, N, the post-divider, the achieved frequency and both codes keep their previous values.
- R8: done_o is high for exactly one cycle per accepted request. busy_o is high from the cycle after the accepted start until done_o rises. A start while busy_o is high is ignored.
- R9: After a successful search, mult_code_o equals M-2 (10 bits) and prediv_code_o equals N-1 (4 bits).
- R10: A start asserted in the same cycle as done_o is accepted and begins a new search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request pulse; inputs sampled with it |
| rate_khz_i | input | 22 | Per-lane data rate in kHz |
| ref_khz_i | input | 17 | Reference clock frequency in kHz |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Last request failed; valid with done_o |
| mult_o | output | 10 | Chosen feedback multiplier M |
| prediv_o | output | 5 | Chosen input divider N |
| postdiv_o | output | 4 | Post-VCO divider (1, 2, 4 or 8) |
| fout_khz_o | output | 21 | Achieved output frequency in kHz |
| mult_code_o | output | 10 | M minus 2 |
| prediv_code_o | output | 4 | N minus 1 |

## Verification
Two events can land in the same cycle: the done pulse of one search and the start of the next. The bench provokes this by raising start in the same cycle in which it sees done_o. It checks that the first result is complete, that the second request runs to its own done, and that the second result matches the model for the second inputs. The opposite case is also tested. A start that arrives mid-search, with different operands, must leave the running search's result unchanged and must produce no extra done.

// File: rtl/pll_srch_pkg.sv
package pll_srch_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_MGO,
        ST_MWAIT,
        ST_FGO,
        ST_FWAIT,
        ST_NEXT,
        ST_FINISH
    } srch_st_e;

endpackage

// File: rtl/pll_srch_window.sv
// Derives the legal pre-divider window from the reference frequency with a
// bank of constant comparators instead of a division.
module pll_srch_window #(
    parameter int REF_W   = 17,
    parameter int NW      = 5,
    parameter int NMAX    = 16,
    parameter int PFD_HI  = 8000,
    parameter int PFD_LO  = 2000
) (
    input  logic [REF_W-1:0] fin_i,
    output logic [NW-1:0]    nmin_o,
    output logic [NW-1:0]    nmax_o
);
    logic [NMAX-1:0] lo_vec;
    logic [NMAX-1:0] hi_vec;

    for (genvar k = 0; k < NMAX; k++) begin : g_cmp
        // ceil(Fin/PFD_HI) counts k >= 0 with k*PFD_HI < Fin
        assign lo_vec[k] = 32'(fin_i) > (k * PFD_HI);
        // floor(Fin/PFD_LO) counts k >= 1 with k*PFD_LO <= Fin
        assign hi_vec[k] = 32'(fin_i) >= ((k + 1) * PFD_LO);
    end

    always_comb begin
        nmin_o = NW'($countones(lo_vec));
        nmax_o = NW'($countones(hi_vec));
        if (nmin_o == '0) nmin_o = NW'(1);
        if (nmax_o == '0) nmax_o = NW'(1);
    end

endmodule

// File: rtl/pll_srch_divider.sv
// Restoring divider: one quotient bit per cycle, NUM_W cycles per division.
module pll_srch_divider #(
    parameter int NUM_W = 30,
    parameter int DEN_W = 17
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             go_i,
    input  logic [NUM_W-1:0] num_i,
    input  logic [DEN_W-1:0] den_i,
    output logic [NUM_W-1:0] quo_o,
    output logic             done_o
);
    localparam int CW = $clog2(NUM_W + 1);

    typedef struct packed {
        logic             busy;
        logic             done;
        logic [CW-1:0]    cnt;
        logic [DEN_W:0]   acc;
        logic [DEN_W-1:0] den;
        logic [NUM_W-1:0] quo;
    } dv_t;

    dv_t dv_d, dv_q;
    logic [DEN_W:0] shifted;

    always_comb begin
        dv_d      = dv_q;
        dv_d.done = 1'b0;
        shifted   = {dv_q.acc[DEN_W-1:0], dv_q.quo[NUM_W-1]};
        if (go_i) begin
            dv_d.busy = 1'b1;
            dv_d.cnt  = CW'(NUM_W);
            dv_d.acc  = '0;
            dv_d.den  = den_i;
            dv_d.quo  = num_i;
        end else if (dv_q.busy) begin
            if (shifted >= {1'b0, dv_q.den}) begin
                dv_d.acc = shifted - {1'b0, dv_q.den};
                dv_d.quo = {dv_q.quo[NUM_W-2:0], 1'b1};
            end else begin
                dv_d.acc = shifted;
                dv_d.quo = {dv_q.quo[NUM_W-2:0], 1'b0};
            end
            dv_d.cnt = dv_q.cnt - 1'b1;
            if (dv_q.cnt == CW'(1)) begin
                dv_d.busy = 1'b0;
                dv_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) dv_q <= '0;
        else         dv_q <= dv_d;
    end

    assign quo_o  = dv_q.quo;
    assign done_o = dv_q.done;

endmodule

// File: rtl/pll_ratio_search.sv
module pll_ratio_search
    import pll_srch_pkg::*;
#(
    parameter int RATE_W    = 22,
    parameter int REF_W     = 17,
    parameter int MW        = 10,
    parameter int NW        = 5,
    parameter int DIVW      = 4,
    parameter int NMAX      = 16,
    parameter int M_MIN     = 64,
    parameter int M_MAX     = 625,
    parameter int RATE_MIN  = 80000,
    parameter int RATE_MAX  = 2500000,
    parameter int REF_MIN   = 2000,
    parameter int REF_MAX   = 64000,
    parameter int F_MIN     = 40000,
    parameter int F_MAX     = 1250000,
    parameter int PFD_HI    = 8000,
    parameter int PFD_LO    = 2000,
    parameter int DIV_STEP  = 80000
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                start_i,
    input  logic [RATE_W-1:0]   rate_khz_i,
    input  logic [REF_W-1:0]    ref_khz_i,
    output logic                busy_o,
    output logic                done_o,
    output logic                err_o,
    output logic [MW-1:0]       mult_o,
    output logic [NW-1:0]       prediv_o,
    output logic [DIVW-1:0]     postdiv_o,
    output logic [RATE_W-2:0]   fout_khz_o,
    output logic [MW-1:0]       mult_code_o,
    output logic [NW-2:0]       prediv_code_o
);
    localparam int FOUT_W = RATE_W - 1;
    localparam int NUM_W  = RATE_W + 8;
    localparam int NCW    = NW - 1;

    localparam logic [RATE_W-1:0] RATE_LO = RATE_W'(RATE_MIN);
    localparam logic [RATE_W-1:0] RATE_HI = RATE_W'(RATE_MAX);
    localparam logic [REF_W-1:0]  REF_LO  = REF_W'(REF_MIN);
    localparam logic [REF_W-1:0]  REF_HI  = REF_W'(REF_MAX);
    localparam logic [NUM_W-1:0]  M_LO    = NUM_W'(M_MIN);
    localparam logic [NUM_W-1:0]  M_HI    = NUM_W'(M_MAX);
    localparam logic [NUM_W-1:0]  F_LO    = NUM_W'(F_MIN);
    localparam logic [NUM_W-1:0]  F_HI    = NUM_W'(F_MAX);
    localparam logic [FOUT_W-1:0] STEP1   = FOUT_W'(DIV_STEP);
    localparam logic [FOUT_W-1:0] STEP2   = FOUT_W'(2 * DIV_STEP);
    localparam logic [FOUT_W-1:0] STEP4   = FOUT_W'(4 * DIV_STEP);

    typedef struct packed {
        srch_st_e           state;
        logic [RATE_W-1:0]  rate;
        logic [REF_W-1:0]   fin;
        logic [FOUT_W-1:0]  fout;
        logic [DIVW-1:0]    pdiv;
        logic [NW-1:0]      n;
        logic [MW-1:0]      m_cur;
        logic               found;
        logic [NUM_W-1:0]   best_err;
        logic [MW-1:0]      best_m;
        logic [NW-1:0]      best_n;
        logic [FOUT_W-1:0]  best_f;
        logic               done;
        logic               err;
        logic [MW-1:0]      m_out;
        logic [NW-1:0]      n_out;
        logic [MW-1:0]      m_code;
        logic [NCW-1:0]     n_code;
        logic [DIVW-1:0]    div_out;
        logic [FOUT_W-1:0]  f_out;
    } srch_t;

    srch_t s_d, s_q;

    logic [NW-1:0]     win_nmin, win_nmax;
    logic              dv_go, dv_done;
    logic [NUM_W-1:0]  dv_num, dv_quo, delta;
    logic [REF_W-1:0]  dv_den;
    logic [FOUT_W-1:0] fout_w;
    logic [DIVW-1:0]   div_sel;

    pll_srch_window #(
        .REF_W (REF_W), .NW (NW), .NMAX (NMAX),
        .PFD_HI(PFD_HI), .PFD_LO(PFD_LO)
    ) win_i (
        .fin_i (s_q.fin),
        .nmin_o(win_nmin),
        .nmax_o(win_nmax)
    );

    pll_srch_divider #(.NUM_W(NUM_W), .DEN_W(REF_W)) div_i (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .go_i  (dv_go),
        .num_i (dv_num),
        .den_i (dv_den),
        .quo_o (dv_quo),
        .done_o(dv_done)
    );

    always_comb begin
        fout_w = s_q.rate[RATE_W-1:1];
        if (fout_w <= STEP1)      div_sel = DIVW'(8);
        else if (fout_w <= STEP2) div_sel = DIVW'(4);
        else if (fout_w <= STEP4) div_sel = DIVW'(2);
        else                      div_sel = DIVW'(1);
        delta = (dv_quo > NUM_W'(s_q.fout)) ? dv_quo - NUM_W'(s_q.fout)
                                            : NUM_W'(s_q.fout) - dv_quo;
    end

    always_comb begin
        s_d    = s_q;
        s_d.done = 1'b0;
        dv_go  = 1'b0;
        dv_num = '0;
        dv_den = '0;
        unique case (s_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    s_d.rate  = rate_khz_i;
                    s_d.fin   = ref_khz_i;
                    s_d.state = ST_CHECK;
                end
            end
            ST_CHECK: begin
                s_d.fout     = fout_w;
                s_d.pdiv     = div_sel;
                s_d.n        = win_nmin;
                s_d.found    = 1'b0;
                s_d.best_err = '1;
                if (s_q.rate < RATE_LO || s_q.rate > RATE_HI ||
                    s_q.fin < REF_LO || s_q.fin > REF_HI)
                    s_d.state = ST_FINISH;
                else
                    s_d.state = ST_MGO;
            end
            ST_MGO: begin
                dv_go  = 1'b1;
                dv_num = NUM_W'(s_q.fout) * NUM_W'(s_q.n) * NUM_W'(s_q.pdiv)
                       + NUM_W'(s_q.fin >> 1);
                dv_den = s_q.fin;
                s_d.state = ST_MWAIT;
            end
            ST_MWAIT: begin
                if (dv_done) begin
                    s_d.m_cur = MW'(dv_quo);
                    s_d.state = (dv_quo < M_LO || dv_quo > M_HI) ? ST_NEXT : ST_FGO;
                end
            end
            ST_FGO: begin
                dv_go  = 1'b1;
                dv_num = NUM_W'(s_q.m_cur) * NUM_W'(s_q.fin);
                dv_den = REF_W'(s_q.n) * REF_W'(s_q.pdiv);
                s_d.state = ST_FWAIT;
            end
            ST_FWAIT: begin
                if (dv_done) begin
                    // strict compare keeps the lowest N on equal error
                    if (dv_quo >= F_LO && dv_quo <= F_HI && delta < s_q.best_err) begin
                        s_d.found    = 1'b1;
                        s_d.best_err = delta;
                        s_d.best_m   = s_q.m_cur;
                        s_d.best_n   = s_q.n;
                        s_d.best_f   = FOUT_W'(dv_quo);
                    end
                    s_d.state = ST_NEXT;
                end
            end
            ST_NEXT: begin
                if (s_q.n >= win_nmax) begin
                    s_d.state = ST_FINISH;
                end else begin
                    s_d.n     = s_q.n + 1'b1;
                    s_d.state = ST_MGO;
                end
            end
            ST_FINISH: begin
                s_d.done = 1'b1;
                s_d.err  = !s_q.found;
                if (s_q.found) begin
                    s_d.m_out   = s_q.best_m;
                    s_d.n_out   = s_q.best_n;
                    s_d.m_code  = s_q.best_m - MW'(2);
                    s_d.n_code  = NCW'(s_q.best_n - NW'(1));
                    s_d.div_out = s_q.pdiv;
                    s_d.f_out   = s_q.best_f;
                end
                s_d.state = ST_IDLE;
            end
            default: s_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s_q       <= '0;
            s_q.state <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o        = (s_q.state != ST_IDLE);
    assign done_o        = s_q.done;
    assign err_o         = s_q.err;
    assign mult_o        = s_q.m_out;
    assign prediv_o      = s_q.n_out;
    assign postdiv_o     = s_q.div_out;
    assign fout_khz_o    = s_q.f_out;
    assign mult_code_o   = s_q.m_code;
    assign prediv_code_o = s_q.n_code;

endmodule

// File: rtl/pll_ratio_search_chk.sv
module pll_ratio_search_chk #(
    parameter int MW    = 10,
    parameter int NW    = 5,
    parameter int DIVW  = 4,
    parameter int FW    = 21,
    parameter int M_MIN = 64,
    parameter int M_MAX = 625,
    parameter int NMAX  = 16,
    parameter int F_MIN = 40000,
    parameter int F_MAX = 1250000
) (
    input logic            clk_i,
    input logic            rst_ni,
    input logic            busy_o,
    input logic            done_o,
    input logic            err_o,
    input logic [MW-1:0]   mult_o,
    input logic [NW-1:0]   prediv_o,
    input logic [DIVW-1:0] postdiv_o,
    input logic [FW-1:0]   fout_khz_o,
    input logic [MW-1:0]   mult_code_o,
    input logic [NW-2:0]   prediv_code_o
);
    AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o); // R8
    AST_DONE_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !busy_o); // R8
    AST_MULT_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && !err_o) |-> (mult_code_o == MW'(mult_o - MW'(2)))); // R9
    AST_PREDIV_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && !err_o) |-> (32'(prediv_code_o) + 1 == 32'(prediv_o))); // R9
    AST_MULT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && !err_o) |-> (32'(mult_o) >= M_MIN && 32'(mult_o) <= M_MAX
                                && prediv_o != '0 && 32'(prediv_o) <= NMAX)); // R4
    AST_POSTDIV_POW2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && !err_o) |-> ($countones(postdiv_o) == 1)); // R3
    AST_FOUT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && !err_o) |-> (32'(fout_khz_o) >= F_MIN && 32'(fout_khz_o) <= F_MAX)); // R5
    AST_ERR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && err_o) |-> ($stable(mult_o) && $stable(prediv_o)
                               && $stable(fout_khz_o) && $stable(postdiv_o))); // R7
endmodule

bind pll_ratio_search pll_ratio_search_chk #(
    .MW(MW), .NW(NW), .DIVW(DIVW), .FW(RATE_W - 1),
    .M_MIN(M_MIN), .M_MAX(M_MAX), .NMAX(NMAX), .F_MIN(F_MIN), .F_MAX(F_MAX)
) chk_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .err_o        (err_o),
    .mult_o       (mult_o),
    .prediv_o     (prediv_o),
    .postdiv_o    (postdiv_o),
    .fout_khz_o   (fout_khz_o),
    .mult_code_o  (mult_code_o),
    .prediv_code_o(prediv_code_o)
);

// File: tb/pll_ratio_search_tb.sv
`timescale 1ns/1ps
module pll_ratio_search_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [21:0] rate = '0;
    logic [16:0] refk = '0;
    logic        busy, done, err;
    logic [9:0]  mult, mcode;
    logic [4:0]  prediv;
    logic [3:0]  postdiv, ncode;
    logic [20:0] fout;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    longint e_m = 0, e_n = 0, e_dv = 0, e_f = 0;

    always #2 clk = ~clk;

    pll_ratio_search dut_i (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start),
        .rate_khz_i(rate), .ref_khz_i(refk),
        .busy_o(busy), .done_o(done), .err_o(err),
        .mult_o(mult), .prediv_o(prediv), .postdiv_o(postdiv),
        .fout_khz_o(fout), .mult_code_o(mcode), .prediv_code_o(ncode)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit model(input longint r, input longint f,
                                 output longint om, output longint on,
                                 output longint od, output longint of);
        longint fo, q, nmin, nmax, mm, ff, e, best;
        om = 0; on = 0; od = 0; of = 0;
        if (r < 80000 || r > 2500000 || f < 2000 || f > 64000) return 1'b0;
        fo = r / 2;
        q = (fo + 79999) / 80000;
        if (q > 8) q = 8;
        od = 8 / q;
        nmin = (f + 7999) / 8000;
        nmax = f / 2000;
        if (nmin < 1) nmin = 1;
        if (nmin > 16) nmin = 16;
        if (nmax < 1) nmax = 1;
        if (nmax > 16) nmax = 16;
        best = -1;
        for (longint nn = nmin; nn <= nmax; nn++) begin
            mm = (fo * nn * od + f / 2) / f;
            if (mm < 64 || mm > 625) continue;
            ff = mm * f / (nn * od);
            if (ff < 40000 || ff > 1250000) continue;
            e = (fo > ff) ? fo - ff : ff - fo;
            if (best < 0 || e < best) begin
                best = e; om = mm; on = nn; of = ff;
            end
        end
        return best >= 0;
    endfunction

    task automatic wait_done(input string req);
        int cyc = 0;
        while (!done && cyc < 5000) begin
            @(negedge clk);
            cyc++;
        end
        chk(done, req, "done within limit", done, 1);
    endtask

    task automatic judge(input longint r, input longint f, input string req);
        longint m, n, dv, fq;
        bit ok;
        ok = model(r, f, m, n, dv, fq);
        chk(err == !ok, req, "err flag", err, !ok);
        if (ok) begin e_m = m; e_n = n; e_dv = dv; e_f = fq; end
        // R7: on failure the results stay at the last good values
        chk(mult == e_m,   ok ? "R4/R6" : "R7", "mult",   mult,   e_m);
        chk(prediv == e_n, ok ? "R4/R6" : "R7", "prediv", prediv, e_n);
        chk(postdiv == e_dv, ok ? "R3" : "R7", "postdiv", postdiv, e_dv);
        chk(fout == e_f,   ok ? "R5" : "R7", "fout", fout, e_f);
        if (ok) begin
            chk(mcode == 10'(m - 2), "R9", "mult code", mcode, m - 2);
            chk(ncode == 4'(n - 1), "R9", "prediv code", ncode, n - 1);
        end
    endtask

    task automatic request(input longint r, input longint f, input string req);
        rate = 22'(r); refk = 17'(f); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy, "R8", "busy after start", busy, 1);
        wait_done(req);
        judge(r, f, req);
        @(negedge clk);
        chk(!done, "R8", "done one cycle", done, 0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : main
        longint r, f;
        void'($urandom(32'd20231016));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !err, "R8", "reset idle", {busy, done, err}, 0);
        chk(mult == 0 && prediv == 0, "R8", "reset results", mult, 0);

        // R1 boundaries
        request(80000, 24000, "R1");
        request(79999, 24000, "R1");
        request(2500000, 24000, "R1");
        request(2500001, 24000, "R1");
        // R2 boundaries
        request(900000, 2000, "R2");
        request(900000, 1999, "R2");
        request(900000, 64000, "R2");
        request(900000, 64001, "R2");
        // R3 divider steps
        request(160000, 27000, "R3");
        request(160002, 27000, "R3");
        request(320000, 19200, "R3");
        request(320002, 19200, "R3");
        request(640000, 33333, "R3");
        request(640002, 33333, "R3");
        // R6 tie-breaking: exact ratios found for several N
        request(1000000, 24000, "R6");
        request(1500000, 12000, "R6");

        // R8: start during a search is ignored
        rate = 22'd1200000; refk = 17'd26000; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
        rate = 22'd90000; refk = 17'd3000; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done("R8");
        judge(1200000, 26000, "R8");
        repeat (3) @(negedge clk);
        chk(!busy && !done, "R8", "no second search", busy, 0);

        // R10: start in the done cycle
        rate = 22'd700000; refk = 17'd19200; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done("R10");
        judge(700000, 19200, "R10");
        rate = 22'd2100000; refk = 17'd50000; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy, "R10", "restart accepted", busy, 1);
        wait_done("R10");
        judge(2100000, 50000, "R10");
        @(negedge clk);

        // constrained random
        for (int i = 0; i < 40; i++) begin
            r = 60000 + longint'($urandom % 2480000);
            f = 1500 + longint'($urandom % 64000);
            request(r, f, "R4");
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule